// File: doc/BRIEF.md
# Throttle Ratio Search Engine

The engine picks the suspend/run split for duty-cycle clock throttling. It is given a wanted frequency, the frequency of the unthrottled clock, and the longest total period allowed in counts. From these it finds the pair of counts (cycles spent suspended, cycles spent running) whose effective rate `full × run / (run + suspend)` lies nearest the wanted frequency. It tries every total from the allowed maximum down to one. For each total it derives the run count by integer division and then computes the rate that split achieves.

Work is sequential. One shared restoring divider serves both divisions of every candidate. A control unit raises `start` for one cycle. The engine latches its inputs and raises `busy`. When the scan is over it pulses `done`, and the chosen counts and achieved frequency stay on the outputs until the next accepted request. If the achieved frequency equals the full frequency, the caller should treat the result as "no throttling" and program both counts as zero.

Top module: `throttle_ratio_search`

## Requirements
- R1: After reset, `busy`, `done` and `zero_full_err` are 0, and `on_count`, `off_count` and `eff_freq` are all 0.
- R2: The best result is seeded as run count 1, suspend count 0 and frequency equal to `full_freq`. When `max_total` is 0 the scan is empty, and this seed is returned with `done`.
- R3: For each total i from N = `max_total` down to 1, the engine uses 32-bit unsigned arithmetic that wraps modulo 2^32 on every product. It computes run = low 8 bits of (target·i / full), suspend = (i − run) modulo 256, and candidate = (full·run) / i. The candidate whose absolute difference from the target is smallest is returned. This holds also for targets above `full_freq`.
- R4: A candidate replaces the current best when its absolute error is less than or equal to the best error. Among equal errors, the smallest total therefore wins. For example, target 50, full 100 and N 4 returns run 1, suspend 1, frequency 50.
- R5: A target equal to `full_freq` returns run 1, suspend 0, frequency `full_freq`.
- R6: A target of 0 with N ≥ 1 returns run 0, suspend 1, frequency 0.
- R7: `busy` is 1 from the cycle after the accepting edge up to and including the `done` cycle. `done` lasts exactly one cycle, and `busy` is 0 in the following cycle.
- R8: A `start` that arrives while `busy` is 1 has no effect. The running scan returns the result for the inputs latched at acceptance, and no second scan follows.
- R9: With `full_freq` equal to 0, `done` comes in the cycle after the accepting edge. `zero_full_err` is then 1 and the outputs are run 1, suspend 0, frequency 0. The next accepted request with nonzero `full_freq` clears `zero_full_err`.
- R10: With N ≥ 1 and nonzero `full_freq`, `done` is high exactly 69·N + 1 cycles after the accepting cycle, which is 2·DATA_W + 5 cycles per candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a search; taken only when idle |
| target_freq | input | 32 | Wanted effective frequency |
| full_freq | input | 32 | Frequency of the unthrottled clock |
| max_total | input | 8 | Longest total period N to try |
| busy | output | 1 | Scan in progress (including the done cycle) |
| done | output | 1 | One-cycle pulse, results valid |
| on_count | output | 8 | Chosen suspend count |
| off_count | output | 8 | Chosen run count |
| eff_freq | output | 32 | Effective frequency achieved by the chosen split |
| zero_full_err | output | 1 | Last request had a zero full frequency |

## Verification
Two situations are hard to reach from the ports. The first is an exact error tie between two totals, where only the less-or-equal rule decides between the longer and the shorter split. The bench uses a target of half the full frequency with N 4, so that totals 4 and 2 both hit the target exactly and the expected winner is the shorter one. The second is a start pulse that lands in the middle of a long scan. Here the bench fires a second request with very different inputs ten cycles after acceptance. It then checks that the result and the cycle count belong to the first request and that busy falls right after done. Wrapping products are reached with operands near 2^30 and 2^31.

// File: rtl/trs_pkg.sv
package trs_pkg;

   // Scan sequencer states
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOAD_Q = 3'd1,   // launch division for run count
      ST_RUN_Q  = 3'd2,
      ST_LOAD_F = 3'd3,   // launch division for candidate frequency
      ST_RUN_F  = 3'd4,
      ST_JUDGE  = 3'd5,   // compare candidate against best
      ST_FINISH = 3'd6
   } trs_state_e;

endpackage

// File: rtl/trs_divider.sv
module trs_divider #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic [W-1:0] quo,
   output logic         done_p
);
   localparam int CW = $clog2(W + 1);

   if (W < 2) begin : g_bad_width
      $error("trs_divider: W must be at least 2");
   end

   logic [W-1:0]  rem_q, quo_q, den_q;
   logic [CW-1:0] left_q;
   logic [W:0]    trial;

   // shifted partial remainder minus divisor; bit W set means negative
   always_comb trial = {rem_q, quo_q[W-1]} - {1'b0, den_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         left_q <= '0;
         done_p <= 1'b0;
      end else begin
         done_p <= 1'b0;
         if (go) begin
            rem_q  <= '0;
            quo_q  <= num;
            den_q  <= den;
            left_q <= CW'(W);
         end else if (left_q != '0) begin
            if (!trial[W]) begin
               rem_q <= trial[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= {rem_q[W-2:0], quo_q[W-1]};
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) done_p <= 1'b1;
         end
      end
   end

   assign quo = quo_q;

   // a finished division leaves a remainder below the divisor
   assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_p |-> (rem_q < den_q));

endmodule

// File: rtl/trs_nearest.sv
module trs_nearest #(
   parameter int W            = 32,
   parameter bit TIE_TO_LATER = 1'b1
) (
   input  logic [W-1:0] goal,
   input  logic [W-1:0] cand,
   input  logic [W-1:0] best,
   output logic         take
);
   logic [W-1:0] err_cand, err_best;

   always_comb begin
      err_cand = (cand >= goal) ? (cand - goal) : (goal - cand);
      err_best = (best >= goal) ? (best - goal) : (goal - best);
   end

   // variant: on equal error the later (shorter) candidate wins, or the earlier one stays
   if (TIE_TO_LATER) begin : g_tie_later
      assign take = (err_cand <= err_best);
   end else begin : g_tie_earlier
      assign take = (err_cand < err_best);
   end

endmodule

// File: rtl/throttle_ratio_search.sv
module throttle_ratio_search
   import trs_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int CNT_W        = 8,
   parameter int TOTAL_CAP    = 255,
   parameter bit TIE_TO_LATER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] target_freq,
   input  logic [DATA_W-1:0] full_freq,
   input  logic [CNT_W-1:0]  max_total,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  on_count,
   output logic [CNT_W-1:0]  off_count,
   output logic [DATA_W-1:0] eff_freq,
   output logic              zero_full_err
);
   localparam logic [CNT_W-1:0] CAP_V = CNT_W'(TOTAL_CAP);

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("throttle_ratio_search: CNT_W exceeds DATA_W");
   end
   if (TOTAL_CAP < 1 || TOTAL_CAP > (2 ** CNT_W) - 1) begin : g_bad_cap
      $error("throttle_ratio_search: TOTAL_CAP out of range");
   end

   trs_state_e        state;
   logic [DATA_W-1:0] tgt_q, fs_q, cand_q, best_f;
   logic [CNT_W-1:0]  idx_q, max_q, run_c_q, best_run, best_susp;
   logic              err_q;
   logic [CNT_W-1:0]  lim;

   logic              div_go, div_done;
   logic [DATA_W-1:0] div_num, div_den, div_quo;
   logic              take;

   always_comb lim = (max_total > CAP_V) ? CAP_V : max_total;

   // operand selection for the shared divider
   always_comb begin
      div_go  = (state == ST_LOAD_Q) || (state == ST_LOAD_F);
      if (state == ST_LOAD_Q) begin
         div_num = tgt_q * DATA_W'(idx_q);
         div_den = fs_q;
      end else begin
         div_num = fs_q * DATA_W'(run_c_q);
         div_den = DATA_W'(idx_q);
      end
   end

   trs_divider #(.W(DATA_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (div_go),
      .num    (div_num),
      .den    (div_den),
      .quo    (div_quo),
      .done_p (div_done)
   );

   trs_nearest #(.W(DATA_W), .TIE_TO_LATER(TIE_TO_LATER)) u_near (
      .goal (tgt_q),
      .cand (cand_q),
      .best (best_f),
      .take (take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tgt_q     <= '0;
         fs_q      <= '0;
         cand_q    <= '0;
         best_f    <= '0;
         idx_q     <= '0;
         max_q     <= '0;
         run_c_q   <= '0;
         best_run  <= '0;
         best_susp <= '0;
         err_q     <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  tgt_q     <= target_freq;
                  fs_q      <= full_freq;
                  max_q     <= lim;
                  idx_q     <= lim;
                  best_f    <= full_freq;
                  best_run  <= CNT_W'(1);
                  best_susp <= '0;
                  err_q     <= (full_freq == '0);
                  if (full_freq == '0 || lim == '0) state <= ST_FINISH;
                  else                              state <= ST_LOAD_Q;
               end
            end
            ST_LOAD_Q: state <= ST_RUN_Q;
            ST_RUN_Q: begin
               if (div_done) begin
                  run_c_q <= div_quo[CNT_W-1:0];
                  state   <= ST_LOAD_F;
               end
            end
            ST_LOAD_F: state <= ST_RUN_F;
            ST_RUN_F: begin
               if (div_done) begin
                  cand_q <= div_quo;
                  state  <= ST_JUDGE;
               end
            end
            ST_JUDGE: begin
               if (take) begin
                  best_f    <= cand_q;
                  best_run  <= run_c_q;
                  best_susp <= idx_q - run_c_q;
               end
               if (idx_q == CNT_W'(1)) state <= ST_FINISH;
               else begin
                  idx_q <= idx_q - 1'b1;
                  state <= ST_LOAD_Q;
               end
            end
            ST_FINISH: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (state != ST_IDLE);
   assign done          = (state == ST_FINISH);
   assign on_count      = best_susp;
   assign off_count     = best_run;
   assign eff_freq      = best_f;
   assign zero_full_err = err_q;

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(tgt_q) && $stable(fs_q) && $stable(max_q)));

   assert_zero_full_seed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && zero_full_err) |-> (on_count == '0 && off_count == CNT_W'(1) && eff_freq == '0));

   assert_total_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !zero_full_err && max_q != '0) |-> (CNT_W'(on_count + off_count) <= max_q));

endmodule

// File: tb/test_throttle_ratio_search.sv
module test_throttle_ratio_search;
   localparam int CLK_PERIOD = 10;
   localparam int CAND_CYC   = 69;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] target_freq = '0, full_freq = '0;
   logic [7:0]  max_total = '0;
   logic        busy, done, zero_full_err;
   logic [7:0]  on_count, off_count;
   logic [31:0] eff_freq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   throttle_ratio_search i_throttle_ratio_search (
      .clk(clk), .rst_n(rst_n), .start(start), .target_freq(target_freq),
      .full_freq(full_freq), .max_total(max_total), .busy(busy), .done(done),
      .on_count(on_count), .off_count(off_count), .eff_freq(eff_freq),
      .zero_full_err(zero_full_err));

   // stimulus: target, full, max_total
   localparam logic [71:0] VECS [0:5] = '{
      {32'd50,          32'd100,         8'd4},
      {32'd133000,      32'd200000,      8'd255},
      {32'd1000,        32'd200000,      8'd255},
      {32'h4000_0000,   32'h8000_0000,   8'd8},
      {32'd250000,      32'd200000,      8'd16},
      {32'd77777,       32'd233333,      8'd100}
   };

   task automatic summary_and_end();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung act=%0d exp<=%0d", cycles, WATCHDOG);
         summary_and_end();
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // nearest-split reference computed from the requirements
   function automatic void ref_search(input logic [31:0] t, input logic [31:0] fs,
                                      input logic [7:0] mx, output logic [7:0] susp_o,
                                      output logic [7:0] run_o, output logic [31:0] f_o);
      logic [31:0] best, prod, cand, dc, db;
      logic [7:0]  run_c;
      best = fs; susp_o = 8'd0; run_o = 8'd1;
      for (int i = int'(mx); i > 0; i--) begin
         prod  = t * 32'(i);
         run_c = 8'(prod / fs);
         cand  = (fs * {24'd0, run_c}) / 32'(i);
         dc = (cand >= t) ? cand - t : t - cand;
         db = (best >= t) ? best - t : t - best;
         if (dc <= db) begin
            best = cand; run_o = run_c; susp_o = 8'(i) - run_c;
         end
      end
      f_o = best;
   endfunction

   // issue one request and wait for done; lat = negedges from acceptance to done
   task automatic launch(input logic [31:0] t, input logic [31:0] fs, input logic [7:0] mx,
                         output int lat);
      @(negedge clk);
      target_freq = t; full_freq = fs; max_total = mx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 30000) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic check_result(input string tag, input logic [7:0] es, input logic [7:0] er,
                               input logic [31:0] ef);
      chk(on_count == es,  {tag, " suspend count"}, on_count, es);
      chk(off_count == er, {tag, " run count"}, off_count, er);
      chk(eff_freq == ef,  {tag, " frequency"}, eff_freq, ef);
   endtask

   initial begin
      int lat;
      logic [7:0]  es, er;
      logic [31:0] ef;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && zero_full_err == 0, "R1 reset flags", {busy, done, zero_full_err}, 0);
      chk(on_count == 0 && off_count == 0 && eff_freq == 0, "R1 reset results",
          eff_freq + on_count + off_count, 0);
      rst_n = 1'b1;

      // R3 vector table against the reference
      for (int v = 0; v < 6; v++) begin
         logic [31:0] t, fs;
         logic [7:0]  mx;
         {t, fs, mx} = VECS[v];
         launch(t, fs, mx, lat);
         ref_search(t, fs, mx, es, er, ef);
         check_result($sformatf("R3 vector %0d", v), es, er, ef);
         chk(lat == CAND_CYC * int'(mx) + 1, "R10 latency", lat, CAND_CYC * int'(mx) + 1);
         chk(zero_full_err == 0, "R9 error clear", zero_full_err, 0);
         @(negedge clk);
         chk(done == 0 && busy == 0, "R7 done single and busy low", {done, busy}, 0);
      end

      // R4 tie goes to the shorter total
      launch(32'd50, 32'd100, 8'd4, lat);
      check_result("R4 tie", 8'd1, 8'd1, 32'd50);

      // R3 wrap of target*total (hand computed)
      launch(32'h4000_0000, 32'h8000_0000, 8'd8, lat);
      check_result("R3 wrap", 8'd1, 8'd1, 32'h4000_0000);

      // R5 target at full speed
      launch(32'd200000, 32'd200000, 8'd12, lat);
      check_result("R5 full speed", 8'd0, 8'd1, 32'd200000);

      // R6 zero target
      launch(32'd0, 32'd100, 8'd3, lat);
      check_result("R6 zero target", 8'd1, 8'd0, 32'd0);

      // R2 empty scan returns the seed
      launch(32'd12345, 32'd99999, 8'd0, lat);
      check_result("R2 seed", 8'd0, 8'd1, 32'd99999);
      chk(lat == 1, "R2 empty scan latency", lat, 1);

      // R9 zero full frequency
      launch(32'd500, 32'd0, 8'd200, lat);
      chk(lat == 1, "R9 immediate finish", lat, 1);
      chk(zero_full_err == 1, "R9 error flag", zero_full_err, 1);
      check_result("R9 seed", 8'd0, 8'd1, 32'd0);
      launch(32'd50, 32'd100, 8'd4, lat);
      chk(zero_full_err == 0, "R9 flag cleared", zero_full_err, 0);

      // R7 busy during scan, R8 start ignored while busy
      @(negedge clk);
      target_freq = 32'd133000; full_freq = 32'd200000; max_total = 8'd40; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1, "R7 busy after accept", busy, 1);
      lat = 1;
      repeat (9) begin @(negedge clk); lat++; end
      target_freq = 32'd1; full_freq = 32'd7; max_total = 8'd3; start = 1'b1;
      @(negedge clk); lat++;
      start = 1'b0;
      while (!done && lat < 30000) begin @(negedge clk); lat++; end
      ref_search(32'd133000, 32'd200000, 8'd40, es, er, ef);
      check_result("R8 ignored start", es, er, ef);
      chk(lat == CAND_CYC * 40 + 1, "R8 latency of first request", lat, CAND_CYC * 40 + 1);
      @(negedge clk);
      chk(busy == 0, "R8 no second scan", busy, 0);
      repeat (3) @(negedge clk);
      chk(busy == 0 && eff_freq == ef, "R8 results held", eff_freq, ef);

      summary_and_end();
   end
endmodule